// File: doc/BRIEF.md
# Serial Command Register Interface

This block accepts one-byte output-enable commands from a host over a three-wire serial link: a frame select (active low), a serial clock and a serial data line. While the frame select is low, the block samples the data line on every falling edge of the serial clock and counts those edges. When the frame select returns high, the captured byte is written to the command register, but only if exactly eight clock edges occurred in the frame. Each command bit enables one output stage. A standby flag is raised whenever every command bit is zero.

All three pins are asynchronous to the block. Each passes through a two-flop synchronizer to the system clock, and its edges are found by comparing the synchronized level with the level from the previous cycle. Per-channel protection inputs can clear a command bit when a channel reports a short circuit and overtemperature at the same time. That clear takes priority over a host write that lands in the same cycle.

Frame control is a two-state machine. `ST_IDLE` ignores the serial clock and waits for a falling frame select; that transition is named *frame_start* and it clears the edge counter. `ST_SHIFT` shifts in data on each falling serial clock (transition *bit_shift*, a self-loop). A rising frame select leaves `ST_SHIFT` for `ST_IDLE` (transition *frame_end*), and the byte is committed if the count is exactly eight.

Top module: `serial_cmd_port`

## Requirements
- R1: After synchronous reset `rst`, `out_en` is 0x00 and `standby` is 1.
- R2: A frame with exactly eight falling serial-clock edges commits its byte, least significant bit first: the bit sampled on the k-th falling edge (k = 0..7) appears on `out_en[k]`.
- R3: Serial-clock edges while `sel_n` is high have no effect on `out_en`.
- R4: A frame with fewer than eight falling serial-clock edges (including zero) leaves `out_en` unchanged.
- R5: A frame with more than eight falling serial-clock edges leaves `out_en` unchanged, and data after the eighth edge is not loaded.
- R6: The edge counter saturates at 15, so a frame with 24 edges (8 modulo 16) still does not commit.
- R7: `standby` is 1 exactly when `out_en` is 0x00.
- R8: When `flt_short[n]` and `flt_hot[n]` are both 1, `out_en[n]` is cleared and stays cleared after the faults go away. Either fault alone has no effect.
- R9: A fault clear on channel n wins over a commit in the same cycle: `out_en[n]` is 0 after that commit, and the other bits take the committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Frame select from host, active low, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| sdat | input | 1 | Serial data from host, asynchronous |
| flt_short | input | 8 | Per-channel short-circuit report, synchronous |
| flt_hot | input | 8 | Per-channel overtemperature report, synchronous |
| out_en | output | 8 | Output-stage enables (the command register) |
| standby | output | 1 | High when all enables are zero |

## Verification
On every cycle, the assertions check that the shift register holds its value in `ST_IDLE` and after the eighth edge, that the counter stays at its ceiling, that the command register changes only on a commit or a fault clear, and that a fault clear always lands on its channel. The bench's scenarios alone can show the end-to-end behaviour: the bit order of committed bytes across all 256 values, frames that are too short or too long (including the 24-edge frame that only saturation rejects), clocks with the frame select high, and a fault that coincides with a commit.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } frame_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= RST_VAL;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import serial_cmd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_lvl,
    input  logic         sck_lvl,
    input  logic         dat_lvl,
    output logic [W-1:0] shift_q,
    output logic         commit
);
    localparam int              CNT_W   = $clog2(W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LEN = CNT_W'(W);

    frame_state_e     state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [W-1:0]     sr_nx;
    logic             cs_prev, sck_prev;
    logic             cs_fall, cs_rise, sck_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    assign cs_fall  = cs_prev & ~cs_lvl;
    assign cs_rise  = ~cs_prev & cs_lvl;
    assign sck_fall = sck_prev & ~sck_lvl;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next state and datapath controls
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        sr_nx    = shift_q;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cs_fall) begin          // frame_start
                    state_nx = ST_SHIFT;
                    cnt_nx   = '0;
                end
            end
            ST_SHIFT: begin
                if (cs_rise) begin          // frame_end
                    state_nx = ST_IDLE;
                    commit   = (cnt == CNT_LEN);
                end else if (sck_fall) begin // bit_shift
                    if (cnt < CNT_LEN) sr_nx = {dat_lvl, shift_q[W-1:1]};
                    if (cnt != CNT_MAX) cnt_nx = cnt + CNT_ONE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            shift_q <= '0;
        end else begin
            cnt     <= cnt_nx;
            shift_q <= sr_nx;
        end
    end

    // R3
    idle_sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> $stable(shift_q));

    // R5
    extra_clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && cnt >= CNT_LEN && sck_fall && !cs_rise) |=> $stable(shift_q));

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && cnt == CNT_MAX && sck_fall && !cs_rise) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/cmd_reg.sv
module cmd_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] flt_short,
    input  logic [W-1:0] flt_hot,
    output logic [W-1:0] cmd_q,
    output logic         standby
);
    logic [W-1:0] kill;
    logic [W-1:0] cmd_nx;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chan
            assign kill[gi]   = flt_short[gi] & flt_hot[gi];
            assign cmd_nx[gi] = kill[gi] ? 1'b0 : (commit ? load_val[gi] : cmd_q[gi]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_nx;
    end

    assign standby = ~|cmd_q;

    // R8
    fault_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (|kill) |=> ((cmd_q & $past(kill)) == '0));

    // R4
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && !(|kill)) |=> $stable(cmd_q));
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic         sclk,
    input  logic         sdat,
    input  logic [W-1:0] flt_short,
    input  logic [W-1:0] flt_hot,
    output logic [W-1:0] out_en,
    output logic         standby
);
    logic         cs_s, sck_s, dat_s;
    logic [W-1:0] shift_q;
    logic         commit;

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d(sel_n), .q(cs_s));
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst(rst), .d(sclk), .q(sck_s));
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst(rst), .d(sdat), .q(dat_s));

    frame_ctrl #(.W(W)) u_frame (
        .clk(clk), .rst(rst),
        .cs_lvl(cs_s), .sck_lvl(sck_s), .dat_lvl(dat_s),
        .shift_q(shift_q), .commit(commit));

    cmd_reg #(.W(W)) u_cmd (
        .clk(clk), .rst(rst),
        .commit(commit), .load_val(shift_q),
        .flt_short(flt_short), .flt_hot(flt_hot),
        .cmd_q(out_en), .standby(standby));

    // R7
    standby_match_chk: assert property (@(posedge clk) disable iff (rst)
        (out_en != '0) |-> !standby);
endmodule

// File: tb/serial_cmd_port_tb.sv
module serial_cmd_port_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdat = 1'b0;
    logic [W-1:0] flt_short = '0;
    logic [W-1:0] flt_hot = '0;
    logic [W-1:0] out_en;
    logic         standby;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_cmd = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_cmd_port #(.W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdat(sdat),
        .flt_short(flt_short), .flt_hot(flt_hot),
        .out_en(out_en), .standby(standby));

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(input string req);
        checks++;
        if (out_en !== exp_cmd || standby !== (exp_cmd == '0)) begin
            errors++;
            $display("FAIL %s out_en=%h standby=%b expected out_en=%h standby=%b",
                     req, out_en, standby, exp_cmd, (exp_cmd == '0));
        end
    endtask

    // one clock pulse on the serial clock with a data bit
    task automatic pulse(input logic b);
        sdat = b;
        sclk = 1'b1;
        wait_cyc(4);
        sclk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_frame(input logic [W-1:0] data, input int nclk);
        sel_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < nclk; i++) begin
            if (i < W) pulse(data[i]);
            else       pulse(~data[i % W]);
        end
        sel_n = 1'b1;
        wait_cyc(6);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        // R1 reset state
        check_out("R1");

        // R2, R7: exhaustive sweep of every byte with an exact eight-clock frame
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 8);
            exp_cmd = 8'(v);
            check_out(v == 0 ? "R7" : "R2");
        end

        send_frame(8'hA5, 8);
        exp_cmd = 8'hA5;
        check_out("R2");

        // R3: clocks while frame select is high
        for (int i = 0; i < 10; i++) pulse(i[0]);
        check_out("R3");

        // R4: short frames, from zero to seven clocks
        for (int n = 0; n < 8; n++) begin
            send_frame(8'h3C, n);
            check_out("R4");
        end

        // R5: long frames
        for (int n = 9; n < 16; n++) begin
            send_frame(8'h5A, n);
            check_out("R5");
        end

        // R6: 24 clocks would wrap a free-running 4-bit counter to eight
        send_frame(8'h0F, 24);
        check_out("R6");
        send_frame(8'hF0, 16);
        check_out("R6");

        // R7: zero committed again asserts standby
        send_frame(8'h00, 8);
        exp_cmd = 8'h00;
        check_out("R7");
        send_frame(8'hFF, 8);
        exp_cmd = 8'hFF;
        check_out("R7");

        // R8: single faults have no effect
        flt_short = 8'h08;
        wait_cyc(3);
        check_out("R8");
        flt_short = 8'h00;
        flt_hot = 8'h08;
        wait_cyc(3);
        check_out("R8");
        // both faults on channel 3 clear its bit
        flt_short = 8'h08;
        wait_cyc(3);
        exp_cmd = 8'hF7;
        check_out("R8");
        flt_short = 8'h00;
        flt_hot = 8'h00;
        wait_cyc(3);
        check_out("R8");

        // R9: fault held on channel 5 through a commit of all ones
        flt_short = 8'h20;
        flt_hot = 8'h20;
        send_frame(8'hFF, 8);
        exp_cmd = 8'hDF;
        check_out("R9");
        flt_short = 8'h00;
        flt_hot = 8'h00;
        wait_cyc(3);
        check_out("R9");

        // R1: reset in mid-operation
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
        exp_cmd = 8'h00;
        check_out("R1");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule